// File: doc/BRIEF.md
# Transmit Automatic Level Controller

This block closes the digital side of the loop that sets the output level of a modem line driver. Two comparators outside the block watch the peak of the signal fed back from the line. One says the peak is under a low threshold, the other says it is over a high threshold. From these two flags the block steps a 3-bit attenuation code up or down. Each code step is worth about 3 dB, so the code spans 0 dB (code 0) to 21 dB (code 7).

Adaptation runs only at the start of a frame. A frame-start pulse opens a window that lasts two bit periods. Inside that window the block makes exactly eight updates, one per quarter bit. Each update either moves the code by one step or leaves it alone. Once the eighth update is done, the code stays frozen until the next frame-start pulse. The next frame picks up from wherever the previous one finished. A per-bit strobe realigns the quarter-bit phase to the modulator's bit boundaries.

The comparator flags come from analog circuits, so each one passes through a synchronizer of SYNC_STAGES flip-flops before it is used. On reset the code is at maximum attenuation, so the first burst cannot overdrive the line.

Top module: `alc_tx_level_ctrl`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `atten_code` is 7 and `adapt_busy` is 0.
- R2: A `frame_start` pulse sampled at a clock edge sets `adapt_busy` to 1 from that edge onward.
- R3: Updates take place at clock edges QUARTER, 2·QUARTER, … 8·QUARTER after the `frame_start` edge (QUARTER = BIT_CYCLES/4, default 4). There are exactly eight of them. `adapt_busy` falls at the edge of the eighth update.
- R4: An update whose synchronized `peak_low` is 1 and `peak_high` is 0 decreases `atten_code` by one. A flag counts as synchronized once it has been held for at least SYNC_STAGES cycles before the update edge.
- R5: An update whose synchronized `peak_high` is 1 and `peak_low` is 0 increases `atten_code` by one.
- R6: An update with both flags 0 leaves `atten_code` unchanged, and it still counts as one of the eight.
- R7: An update with both flags 1 is treated as over the high threshold, so the code increases by one.
- R8: `atten_code` saturates at 0 and at 7. A request that would move it past either limit leaves it unchanged.
- R9: While `adapt_busy` is 0, `atten_code` does not change, whatever the comparator flags do.
- R10: A new window starts from the code left by the previous window.
- R11: A `frame_start` pulse during an active window restarts the window. Eight further updates then follow, timed from the new pulse.
- R12: A `bit_tick` during a window restarts the quarter-bit phase, so the next update comes QUARTER edges after the `bit_tick` edge. If `bit_tick` lands on an update edge, that update still takes place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| frame_start | input | 1 | One-cycle pulse marking the start of a new frame |
| bit_tick | input | 1 | One-cycle strobe at each bit boundary |
| peak_low | input | 1 | Comparator: feedback peak below low threshold (asynchronous) |
| peak_high | input | 1 | Comparator: feedback peak above high threshold (asynchronous) |
| atten_code | output | 3 | Attenuation code, 3 dB per step, registered |
| adapt_busy | output | 1 | Adaptation window open, registered |

## Verification
A wrong update count or a wrong quarter-bit phase shows up on `adapt_busy`: it falls too early or too late, within one window of about 32 cycles. A wrong step direction or a broken saturation shows up on `atten_code` at the first update edge where it matters, no later than QUARTER edges after the window opens. State carried wrongly between frames can only be seen on the following window. For that reason the directed sequences chain windows together and check the starting code of each one.

// File: rtl/alc_pkg.sv
package alc_pkg;

  // Decision taken at one update point.
  typedef enum logic [1:0] {
    STEP_HOLD = 2'd0,
    STEP_UP   = 2'd1,   // more attenuation, less gain
    STEP_DOWN = 2'd2    // less attenuation, more gain
  } alc_step_e;

endpackage

// File: rtl/alc_flag_sync.sv
module alc_flag_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);

  logic [WIDTH-1:0] chain_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain_q[s] <= '0;
          else     chain_q[s] <= async_i;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain_q[s] <= '0;
          else     chain_q[s] <= chain_q[s-1];
        end
      end
    end
  endgenerate

  assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/alc_window_timer.sv
module alc_window_timer #(
  parameter int QUARTER = 4,
  parameter int UPDATES = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic frame_start,
  input  logic bit_tick,
  output logic active_o,
  output logic update_o
);

  localparam int SUB_W = (QUARTER > 1) ? $clog2(QUARTER) : 1;
  localparam int UPD_W = (UPDATES > 1) ? $clog2(UPDATES) : 1;
  localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(QUARTER - 1);
  localparam logic [UPD_W-1:0] UPD_LAST = UPD_W'(UPDATES - 1);

  logic [SUB_W-1:0] sub_q;
  logic [UPD_W-1:0] upd_q;
  logic             active_q;
  logic             sub_wrap;

  assign sub_wrap = (sub_q == SUB_LAST);

  // A frame start on the same edge wins over a pending update.
  assign update_o = active_q && sub_wrap && !frame_start;
  assign active_o = active_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      sub_q    <= '0;
      upd_q    <= '0;
    end else if (frame_start) begin
      active_q <= 1'b1;
      sub_q    <= '0;
      upd_q    <= '0;
    end else if (active_q) begin
      if (sub_wrap || bit_tick) sub_q <= '0;
      else                      sub_q <= sub_q + 1'b1;
      if (sub_wrap) begin
        if (upd_q == UPD_LAST) begin
          active_q <= 1'b0;
          upd_q    <= '0;
        end else begin
          upd_q <= upd_q + 1'b1;
        end
      end
    end
  end

  // R2
  frame_opens_chk: assert property (@(posedge clk) disable iff (rst)
    frame_start |=> active_q);

  // R3
  idle_count_clear_chk: assert property (@(posedge clk) disable iff (rst)
    !active_q |-> (upd_q == '0 && sub_q == '0));

  // R3
  last_update_closes_chk: assert property (@(posedge clk) disable iff (rst)
    (update_o && upd_q == UPD_LAST) |=> !active_q);

  // R12
  tick_resync_chk: assert property (@(posedge clk) disable iff (rst)
    (active_q && bit_tick && !frame_start && !(sub_wrap && upd_q == UPD_LAST)) |=> (sub_q == '0));

endmodule

// File: rtl/alc_step_decide.sv
module alc_step_decide
  import alc_pkg::*;
(
  input  logic      below_i,
  input  logic      above_i,
  output alc_step_e step_o
);

  // Over-threshold has priority: when both flags are set, back off.
  always_comb begin
    if (above_i)      step_o = STEP_UP;
    else if (below_i) step_o = STEP_DOWN;
    else              step_o = STEP_HOLD;
  end

endmodule

// File: rtl/alc_atten_reg.sv
module alc_atten_reg
  import alc_pkg::*;
#(
  parameter int CODE_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              update_i,
  input  alc_step_e         step_i,
  output logic [CODE_W-1:0] code_o
);

  localparam logic [CODE_W-1:0] CODE_MAX = {CODE_W{1'b1}};
  localparam logic [CODE_W-1:0] CODE_MIN = '0;

  logic [CODE_W-1:0] code_q;
  logic [CODE_W-1:0] code_d;

  always_comb begin
    code_d = code_q;
    if (update_i) begin
      unique case (step_i)
        STEP_UP:   if (code_q != CODE_MAX) code_d = code_q + 1'b1;
        STEP_DOWN: if (code_q != CODE_MIN) code_d = code_q - 1'b1;
        default:   code_d = code_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) code_q <= CODE_MAX;
    else     code_q <= code_d;
  end

  assign code_o = code_q;

  // R4
  single_step_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (code_q == $past(code_q) || code_q == $past(code_q) + 1'b1 ||
              code_q + 1'b1 == $past(code_q)));

  // R8
  top_sat_chk: assert property (@(posedge clk) disable iff (rst)
    (code_q == CODE_MAX && step_i == STEP_UP) |=> (code_q == CODE_MAX));

  // R8
  bottom_sat_chk: assert property (@(posedge clk) disable iff (rst)
    (code_q == CODE_MIN && step_i == STEP_DOWN) |=> (code_q == CODE_MIN));

  // R6
  hold_step_chk: assert property (@(posedge clk) disable iff (rst)
    (step_i == STEP_HOLD) |=> $stable(code_q));

endmodule

// File: rtl/alc_tx_level_ctrl.sv
module alc_tx_level_ctrl
  import alc_pkg::*;
#(
  parameter int CODE_W      = 3,
  parameter int BIT_CYCLES  = 16,
  parameter int WINDOW_BITS = 2,
  parameter int UPDATES     = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_start,
  input  logic              bit_tick,
  input  logic              peak_low,
  input  logic              peak_high,
  output logic [CODE_W-1:0] atten_code,
  output logic              adapt_busy
);

  localparam int UPD_PER_BIT = UPDATES / WINDOW_BITS;
  localparam int QUARTER     = BIT_CYCLES / UPD_PER_BIT;

  logic [1:0] flags_sync;
  logic       upd_strobe;
  logic       win_active;
  alc_step_e  step;

  alc_flag_sync #(
    .STAGES (SYNC_STAGES),
    .WIDTH  (2)
  ) u_sync (
    .clk     (clk),
    .rst     (rst),
    .async_i ({peak_high, peak_low}),
    .sync_o  (flags_sync)
  );

  alc_window_timer #(
    .QUARTER (QUARTER),
    .UPDATES (UPDATES)
  ) u_timer (
    .clk         (clk),
    .rst         (rst),
    .frame_start (frame_start),
    .bit_tick    (bit_tick),
    .active_o    (win_active),
    .update_o    (upd_strobe)
  );

  alc_step_decide u_decide (
    .below_i (flags_sync[0]),
    .above_i (flags_sync[1]),
    .step_o  (step)
  );

  alc_atten_reg #(
    .CODE_W (CODE_W)
  ) u_atten (
    .clk      (clk),
    .rst      (rst),
    .update_i (upd_strobe),
    .step_i   (step),
    .code_o   (atten_code)
  );

  assign adapt_busy = win_active;

  // R9
  frozen_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !adapt_busy |=> $stable(atten_code));

  // R1
  reset_value_chk: assert property (@(posedge clk)
    rst |=> (atten_code == {CODE_W{1'b1}} && !adapt_busy));

endmodule

// File: tb/test_alc_tx_level_ctrl.sv
`timescale 1ns/1ps
module test_alc_tx_level_ctrl;

  localparam int Q = 4;   // BIT_CYCLES 16 / 4 updates per bit

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       frame_start = 1'b0;
  logic       bit_tick = 1'b0;
  logic       peak_low = 1'b0;
  logic       peak_high = 1'b0;
  logic [2:0] atten_code;
  logic       adapt_busy;

  int n_run = 0;
  int n_fail = 0;
  bit finished = 0;
  int exp_code = 7;

  always #2.5 clk = ~clk;

  alc_tx_level_ctrl i_alc_tx_level_ctrl (
    .clk         (clk),
    .rst         (rst),
    .frame_start (frame_start),
    .bit_tick    (bit_tick),
    .peak_low    (peak_low),
    .peak_high   (peak_high),
    .atten_code  (atten_code),
    .adapt_busy  (adapt_busy)
  );

  task automatic check(string req, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic edges(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  // Leaves the bench at the falling edge right after the frame_start edge.
  task automatic pulse_frame();
    frame_start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    frame_start = 1'b0;
  endtask

  function automatic int next_code(int c, bit lo, bit hi);
    if (hi)      return (c < 7) ? c + 1 : 7;
    else if (lo) return (c > 0) ? c - 1 : 0;
    return c;
  endfunction

  // One full window with constant flags; checks timing, steps and freeze.
  task automatic run_window(string req, bit lo, bit hi);
    peak_low  = lo;
    peak_high = hi;
    edges(2);
    pulse_frame();
    check({req, " R2 busy after frame"}, adapt_busy, 1);
    for (int k = 1; k <= 8; k++) begin
      edges(Q - 1);
      check({req, " R3 code before update"}, atten_code, exp_code);
      check("R3 busy before update", adapt_busy, 1);
      edges(1);
      exp_code = next_code(exp_code, lo, hi);
      check({req, " code after update"}, atten_code, exp_code);
    end
    check("R3 busy drops after eighth", adapt_busy, 0);
    peak_low  = ~lo;
    peak_high = ~hi;
    edges(20);
    check("R9 code frozen after window", atten_code, exp_code);
    check("R9 busy stays low", adapt_busy, 0);
  endtask

  task automatic t_reset();
    check("R1 code in reset", atten_code, 7);
    check("R1 busy in reset", adapt_busy, 0);
    rst = 1'b0;
    edges(1);
    check("R1 code after reset", atten_code, 7);
    check("R1 busy after reset", adapt_busy, 0);
  endtask

  task automatic t_restart();
    peak_low  = 1'b1;
    peak_high = 1'b0;
    edges(2);
    pulse_frame();
    edges(3 * Q);
    exp_code = 4;
    check("R11 code after three updates", atten_code, exp_code);
    peak_low = 1'b0;
    pulse_frame();
    check("R11 busy after restart", adapt_busy, 1);
    edges(8 * Q - 1);
    check("R11 busy before new eighth", adapt_busy, 1);
    edges(1);
    check("R11 busy after new eighth", adapt_busy, 0);
    check("R11 R6 code held", atten_code, exp_code);
  endtask

  task automatic t_bit_resync();
    peak_low  = 1'b1;
    peak_high = 1'b0;
    edges(2);
    pulse_frame();
    edges(1);
    bit_tick = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bit_tick = 1'b0;
    edges(Q - 2);
    check("R12 no update at old phase", atten_code, exp_code);
    edges(2);
    exp_code = next_code(exp_code, 1'b1, 1'b0);
    check("R12 update at new phase", atten_code, exp_code);
    edges(7 * Q - 1);
    check("R12 busy before last", adapt_busy, 1);
    edges(1);
    check("R12 busy after last", adapt_busy, 0);
    for (int k = 0; k < 7; k++) exp_code = next_code(exp_code, 1'b1, 1'b0);
    check("R12 R8 final code", atten_code, exp_code);
  endtask

  initial begin
    edges(3);
    t_reset();
    run_window("R4 R8 low", 1'b1, 1'b0);
    run_window("R7 both", 1'b1, 1'b1);
    run_window("R6 none", 1'b0, 1'b0);
    t_restart();
    run_window("R10 R5 R8 high", 1'b0, 1'b1);
    t_bit_resync();
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #100000;
    if (!finished) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule